// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block sequences a serial peripheral core between three operating states: reset, run and pause. A simple register port lets software request a state by writing a code into a state register. The block then takes a fixed number of cycles to settle the change. It shows the new state with a valid flag once that time has passed. Shifting on the serial side is enabled only in run. In pause the FIFOs may still be filled, but nothing shifts. Entering reset emits a one-cycle flush strobe that clears the FIFOs and the transfer counters.

The state register is protected in two ways. A request is honoured only while the valid flag is high. Leaving pause for reset needs the clear code written twice in a row. A separate soft-reset register forces reset at once, from any condition, and wipes the datapath configuration register.

Top module: `periph_state_ctrl`

## Requirements
- R1: After reset the state field reads 0 (reset), valid reads 1, the error bit reads 0, the configuration register reads 0, and shift_en, fifo_load_en and flush_pulse are low.
- R2: Address 0 reads {user bits [15:4], error [3], valid [2], state [1:0]}. The state codes are 0 = reset, 1 = run and 3 = pause. Bits [15:4] take the written value on every write that is accepted while valid is high. Bits [3:2] are read-only.
- R3: An accepted request for a new state drops valid for BUSY_CYC cycles (default 4), starting in the cycle after the write. The state field changes in the same cycle that valid rises again.
- R4: A write to address 0 while valid is low changes neither the state nor the user bits. It sets the sticky error bit 3.
- R5: From pause, reset is reached only by writing code 2 (clear) on two consecutive address-0 writes. A single clear leaves the block in pause with valid high. In pause, code 0 is ignored. Outside pause, code 2 does not change the state.
- R6: A clear write followed by any other address-0 write cancels the pending pause-to-reset sequence, so the next clear counts as a first clear.
- R7: Writing 1 to bit 0 at address 2 forces reset in the next cycle, with valid high. It also clears the configuration register and the error bit.
- R8: flush_pulse is high for exactly one cycle: the cycle in which the state field first reads reset after a transition from another state, or the cycle after a soft reset.
- R9: shift_en is high only in run with valid high. fifo_load_en is high only in run or pause with valid high.
- R10: Address 1 is a CFG_W-bit configuration register that can be read and written at any time and drives cfg_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (2) | Register address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data for bus_addr |
| shift_en | output | 1 | Serial shifting allowed |
| fifo_load_en | output | 1 | FIFO loading allowed |
| flush_pulse | output | 1 | One-cycle FIFO and counter flush |
| cfg_out | output | CFG_W (8) | Datapath configuration |
| core_state | output | 2 | Committed state code |
| state_valid | output | 1 | Transition complete |

## Verification
A wrong internal state shows up at the ports no later than BUSY_CYC + 1 cycles after the write that causes it. A lost or extra arm of the clear sequence appears as a state field that leaves pause one write too early or too late. A busy counter of the wrong length moves the rising edge of state_valid, and the bench samples every cycle of that window. A transition that commits a wrong state appears at once on shift_en and fifo_load_en, and a misplaced flush appears on flush_pulse in the wrong cycle.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    PSC_RESET = 2'd0,
    PSC_RUN   = 2'd1,
    PSC_CLEAR = 2'd2,
    PSC_PAUSE = 2'd3
  } psc_code_e;

  localparam int unsigned ADDR_STATE = 0;
  localparam int unsigned ADDR_CFG   = 1;
  localparam int unsigned ADDR_SWRST = 2;
endpackage

// File: rtl/psc_seq.sv
module psc_seq
  import psc_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [1:0] wr_code,
  input  logic       swrst,
  output logic [1:0] state_o,
  output logic       valid_o,
  output logic       err_o,
  output logic       enter_rst_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY = CW'(BUSY_CYC);

  psc_code_e     state_q, state_d, pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          arm_q, arm_d, err_q, err_d;
  logic          idle;

  assign idle = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    arm_d   = arm_q;
    err_d   = err_q;
    if (swrst) begin
      state_d = PSC_RESET;
      cnt_d   = '0;
      arm_d   = 1'b0;
      err_d   = 1'b0;
    end else if (!idle) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) state_d = pend_q;
      if (st_wr) err_d = 1'b1;
    end else if (st_wr) begin
      arm_d = 1'b0;
      unique case (psc_code_e'(wr_code))
        PSC_CLEAR: begin
          if (state_q == PSC_PAUSE) begin
            if (arm_q) begin
              pend_d = PSC_RESET;
              cnt_d  = BUSY;
            end else begin
              arm_d = 1'b1;
            end
          end
        end
        PSC_RESET: begin
          if (state_q != PSC_PAUSE) begin
            pend_d = PSC_RESET;
            cnt_d  = BUSY;
          end
        end
        default: begin
          pend_d = psc_code_e'(wr_code);
          cnt_d  = BUSY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PSC_RESET;
      pend_q  <= PSC_RESET;
      cnt_q   <= '0;
      arm_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      arm_q   <= arm_d;
      err_q   <= err_d;
    end
  end

  assign state_o     = state_q;
  assign valid_o     = idle;
  assign err_o       = err_q;
  assign enter_rst_o = swrst || ((state_d == PSC_RESET) && (state_q != PSC_RESET));

  // R3: accepted run/pause request makes the block busy next cycle
  a_r3_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && idle && (wr_code == PSC_RUN || wr_code == PSC_PAUSE)) |=> (cnt_q != '0));
  // R3: state holds during the busy window
  a_r3_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q > CW'(1)) && !swrst) |=> $stable(state_q));
  // R4: write while busy sets the sticky error
  a_r4_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !idle && !swrst) |=> err_q);
  // R5: first clear in pause keeps pause and valid
  a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && idle && wr_code == PSC_CLEAR && state_q == PSC_PAUSE && !arm_q)
      |=> (state_q == PSC_PAUSE && cnt_q == '0));
  // R7: soft reset lands in reset, valid, error cleared
  a_r7_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (state_q == PSC_RESET && cnt_q == '0 && !err_q));
endmodule

// File: rtl/psc_bus_if.sv
module psc_bus_if
  import psc_pkg::*;
#(
  parameter int unsigned AW    = 2,
  parameter int unsigned DW    = 16,
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             st_wr,
  output logic [1:0]       wr_code,
  output logic             swrst,
  input  logic [1:0]       state_i,
  input  logic             valid_i,
  input  logic             err_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int unsigned UW = DW - 4;

  logic [UW-1:0]    ub_q, ub_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_wr, ub_en, cfg_en;

  assign st_wr   = bus_we && (bus_addr == AW'(ADDR_STATE));
  assign cfg_wr  = bus_we && (bus_addr == AW'(ADDR_CFG));
  assign swrst   = bus_we && (bus_addr == AW'(ADDR_SWRST)) && bus_wdata[0];
  assign wr_code = bus_wdata[1:0];

  assign ub_en  = st_wr && valid_i;
  assign cfg_en = cfg_wr || swrst;

  always_comb begin
    ub_d  = ub_en ? bus_wdata[DW-1:4] : ub_q;
    cfg_d = cfg_q;
    if (swrst)       cfg_d = '0;
    else if (cfg_wr) cfg_d = bus_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ub_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (ub_en)  ub_q  <= ub_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_STATE))    bus_rdata = {ub_q, err_i, valid_i, state_i};
    else if (bus_addr == AW'(ADDR_CFG)) bus_rdata = {{(DW-CFG_W){1'b0}}, cfg_q};
  end

  assign cfg_o = cfg_q;

  // R2: accepted write captures the user bits
  a_r2_user_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && valid_i) |=> (ub_q == $past(bus_wdata[DW-1:4])));
  // R10: configuration write is visible next cycle
  a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_o == $past(bus_wdata[CFG_W-1:0])));
  // R7: soft reset wipes the configuration
  a_r7_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (cfg_o == '0));
endmodule

// File: rtl/psc_enables.sv
module psc_enables
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] state_i,
  input  logic       valid_i,
  input  logic       enter_rst_i,
  output logic       shift_en,
  output logic       fifo_load_en,
  output logic       flush_pulse
);
  logic flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= enter_rst_i;
  end

  assign shift_en     = valid_i && (state_i == PSC_RUN);
  assign fifo_load_en = valid_i && ((state_i == PSC_RUN) || (state_i == PSC_PAUSE));
  assign flush_pulse  = flush_q;

  // R8: a flush is only seen with reset committed and valid
  a_r8_flush_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (state_i == PSC_RESET && valid_i));
endmodule

// File: rtl/periph_state_ctrl.sv
module periph_state_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned AW       = 2,
  parameter int unsigned DW       = 16,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             shift_en,
  output logic             fifo_load_en,
  output logic             flush_pulse,
  output logic [CFG_W-1:0] cfg_out,
  output logic [1:0]       core_state,
  output logic             state_valid
);
  logic rst_meta, rst_sync;
  logic st_wr, swrst, err, enter_rst;
  logic [1:0] wr_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  psc_bus_if #(.AW(AW), .DW(DW), .CFG_W(CFG_W)) u_bus (
    .clk(clk), .rst_n(rst_sync), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_wr(st_wr),
    .wr_code(wr_code), .swrst(swrst), .state_i(core_state),
    .valid_i(state_valid), .err_i(err), .cfg_o(cfg_out)
  );

  psc_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync), .st_wr(st_wr), .wr_code(wr_code),
    .swrst(swrst), .state_o(core_state), .valid_o(state_valid),
    .err_o(err), .enter_rst_o(enter_rst)
  );

  psc_enables u_en (
    .clk(clk), .rst_n(rst_sync), .state_i(core_state), .valid_i(state_valid),
    .enter_rst_i(enter_rst), .shift_en(shift_en), .fifo_load_en(fifo_load_en),
    .flush_pulse(flush_pulse)
  );
endmodule

// File: tb/periph_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module periph_state_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        shift_en, fifo_load_en, flush_pulse, state_valid;
  logic [7:0]  cfg_out;
  logic [1:0]  core_state;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  periph_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shift_en(shift_en),
    .fifo_load_en(fifo_load_en), .flush_pulse(flush_pulse), .cfg_out(cfg_out),
    .core_state(core_state), .state_valid(state_valid)
  );

  // {addr, wdata, expected addr-0 readback, shift_en, fifo_load_en}
  localparam int NV = 9;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {2'd0, 16'h0001, 16'h0005, 1'b1, 1'b1},  // R2 R9 reset->run
    {2'd0, 16'h0003, 16'h0007, 1'b0, 1'b1},  // R9 run->pause
    {2'd0, 16'h0002, 16'h0007, 1'b0, 1'b1},  // R5 first clear stays pause
    {2'd0, 16'h0000, 16'h0007, 1'b0, 1'b1},  // R5 R6 code 0 ignored, cancels
    {2'd0, 16'h0002, 16'h0007, 1'b0, 1'b1},  // R6 counts as first clear
    {2'd0, 16'h0002, 16'h0004, 1'b0, 1'b0},  // R5 second clear -> reset
    {2'd0, 16'hA5F1, 16'hA5F5, 1'b1, 1'b1},  // R2 user bits kept, run
    {2'd0, 16'h0002, 16'h0005, 1'b1, 1'b1},  // R5 clear outside pause
    {2'd0, 16'h0000, 16'h0004, 1'b0, 1'b0}   // R9 run->reset
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk(r == 16'h0004, "R1 state reg", r, 16'h0004);
    rd(2'd1, r); chk(r == 16'h0000, "R1 cfg reg", r, 16'h0000);
    chk({shift_en, fifo_load_en, flush_pulse} == 3'b000, "R1 outputs",
        {shift_en, fifo_load_en, flush_pulse}, 3'b000);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:34], VEC[i][33:18]);
      repeat (4) @(negedge clk);
      rd(2'd0, r);
      chk(r == VEC[i][17:2], "R2/R5/R6 readback", r, VEC[i][17:2]);
      chk({shift_en, fifo_load_en} == VEC[i][1:0], "R9 enables",
          {shift_en, fifo_load_en}, VEC[i][1:0]);
    end

    // R3 busy window timing
    wr(2'd0, 16'h0001);
    chk(!state_valid && core_state == 2'd0, "R3 busy start",
        {state_valid, core_state}, 3'b000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!state_valid && core_state == 2'd0 && !shift_en, "R3 still busy",
          {state_valid, core_state}, 3'b000);
    end
    @(negedge clk);
    chk(state_valid && core_state == 2'd1, "R3 commit", {state_valid, core_state}, 3'b101);

    // R8 flush on transition into reset
    wr(2'd0, 16'h0000);
    repeat (3) @(negedge clk);
    chk(!flush_pulse && core_state == 2'd1, "R8 no early flush", {flush_pulse, core_state}, 3'b001);
    @(negedge clk);
    chk(flush_pulse && core_state == 2'd0, "R8 flush at reset entry", {flush_pulse, core_state}, 3'b100);
    @(negedge clk);
    chk(!flush_pulse, "R8 flush one cycle", flush_pulse, 0);

    // R4 write while busy is ignored and flags error
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'hFFF3);
    repeat (4) @(negedge clk);
    rd(2'd0, r); chk(r == 16'h000D, "R4 ignored, error set", r, 16'h000D);

    // R10 config register
    wr(2'd1, 16'h005A);
    rd(2'd1, r); chk(r == 16'h005A, "R10 cfg readback", r, 16'h005A);
    chk(cfg_out == 8'h5A, "R10 cfg_out", cfg_out, 8'h5A);

    // R7 soft reset from run with error set
    wr(2'd2, 16'h0001);
    chk(core_state == 2'd0 && state_valid, "R7 forced reset", {state_valid, core_state}, 3'b100);
    chk(flush_pulse, "R8 flush on soft reset", flush_pulse, 1);
    rd(2'd1, r); chk(r == 16'h0000 && cfg_out == 8'h00, "R7 cfg cleared", r, 0);
    rd(2'd0, r); chk(r[3] == 1'b0, "R7 error cleared", r, 16'h0004);
    @(negedge clk);
    chk(!flush_pulse, "R8 flush ends", flush_pulse, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule